// File: doc/BRIEF.md
# Serial Audio Link Power-Down and Wakeup Sequencer

This block sits on the controller side of a serial audio codec link. It follows the link through normal running, power-down and warm-reset wakeup. The frame formatter tells it two things: that the outgoing frame carries the codec power-down write, and when that frame reaches the point where the bit clock must be taken as stopped. From that point the sequencer holds the frame sync and serial data outputs low. It then times a lockout of four frame periods on the system clock, because no bit clock runs during this time.

Software asks for a wakeup with a one-cycle request. The sequencer drives sync high for at least one microsecond of system clock time, which acts as an asynchronous wakeup. It then drops sync and waits until bit-clock edges arrive again. A request made during the lockout is held and starts the pulse as soon as the lockout ends. While the link is running, the formatter's sync and data pass straight through. A separate output tells the formatter when the data slots of the current frame must be tagged invalid.

Top module: `aclink_pm_seq`

## Requirements
- R1: After reset the state output is 0 (running), link_up_o is 1, data_slot_en_o is 1, and sync_o/sdo_o follow sync_i/sdo_i. The state codes are 0 running, 1 power-down frame, 2 lockout, 3 down, 4 wake pulse and 5 wait for clock.
- R2: While running, wake_req_i and pd_cut_i have no effect: the state stays 0 and the outputs keep following the inputs.
- R3: A pd_arm_i pulse while running moves the state to 1 on the next cycle. In state 1 data_slot_en_o is 0, so slots 3 to 12 carry no valid data, while sync and data still pass through and link_up_o stays 1.
- R4: A pd_cut_i pulse in state 1 moves the state to 2 on the next cycle. In states 2, 3 and 5, sync_o and sdo_o are 0 whatever the inputs, and link_up_o is 0.
- R5: The lockout lasts exactly 4*FRAME_CYC system cycles, with FRAME_CYC = ceil(256*SYS_CLK_HZ/BCLK_HZ). This is 10420 cycles at the defaults. If no wake request arrived, the state then becomes 3.
- R6: A wake_req_i pulse in state 3 moves the state to 4 on the next cycle. sync_o is then 1 and sdo_o is 0 for exactly ceil(SYS_CLK_HZ*PULSE_NS/1e9) cycles (125 at the defaults). After that the state is 5 and sync_o is 0.
- R7: A wake_req_i pulse during the lockout does not shorten it. When the lockout ends, the state goes straight to 4.
- R8: In state 5 the state returns to 0 only after 3 rising edges of bit_clk_i, seen through a synchronizer, fall within one window of WINDOW_CYC system cycles. Fewer edges, or no clock, leave the state at 5.
- R9: data_slot_en_o is 1 only in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low reset |
| bit_clk_i | input | 1 | Link bit clock from the codec, asynchronous |
| sync_i | input | 1 | Sync from the frame formatter |
| sdo_i | input | 1 | Serial data from the frame formatter |
| pd_arm_i | input | 1 | Pulse: the outgoing frame carries the power-down write |
| pd_cut_i | input | 1 | Pulse: slot 2 bit 4 of that frame is on the wire |
| wake_req_i | input | 1 | Pulse: software wakeup request |
| sync_o | output | 1 | Sync driven onto the link |
| sdo_o | output | 1 | Serial data driven onto the link |
| data_slot_en_o | output | 1 | Data slots of the current frame may be tagged valid |
| link_up_o | output | 1 | Bit clock is taken as present |
| state_o | output | 3 | Sequencer state code |

## Verification
The pass-through path is driven with all four sync and data combinations. This shows that each output follows its own input and that the two are not swapped or tied together. The lockout and the wake pulse are checked on the last cycle inside each state and on the first cycle after it, which separates an exact count from one cycle too many or too few. Wake requests are sent while running, while down and in the middle of the lockout. This covers a request that is ignored, one that acts at once and one that is held. The clock detector is given no clock, a burst of only two edges, and then a steady clock, so a detector that counts too few edges is caught.

// File: rtl/aclink_pm_pkg.sv
package aclink_pm_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_PDFRM   = 3'd1,
        ST_LOCK    = 3'd2,
        ST_DOWN    = 3'd3,
        ST_WAKE    = 3'd4,
        ST_WAITCLK = 3'd5
    } link_st_e;

    typedef struct packed {
        link_st_e st;
        logic     pend;
    } seq_s;

    function automatic longint ceil_div(input longint num, input longint den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/aclink_pm_timer.sv
module aclink_pm_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             done_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done_o = (cnt_q == '0);

    // The timer counts down by one per cycle unless it is reloaded (R5, R6)
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/aclink_bclk_detect.sv
module aclink_bclk_detect #(
    parameter int SYNC_STAGES  = 2,
    parameter int WINDOW_CYC   = 64,
    parameter int EDGES_NEEDED = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic enable_i,
    output logic alive_o
);

    localparam int WIN_W  = $clog2(WINDOW_CYC + 1);
    localparam int EDGE_W = $clog2(EDGES_NEEDED + 1);

    logic [SYNC_STAGES-1:0] sync_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= bclk_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    typedef struct packed {
        logic [WIN_W-1:0]  win;
        logic [EDGE_W-1:0] edges;
        logic              prev;
    } det_s;

    det_s det_d, det_q;
    logic rise;

    assign rise = sync_q[SYNC_STAGES-1] & ~det_q.prev;

    always_comb begin
        det_d      = det_q;
        det_d.prev = sync_q[SYNC_STAGES-1];
        if (!enable_i) begin
            det_d.win   = '0;
            det_d.edges = '0;
        end else if (det_q.win == WIN_W'(WINDOW_CYC - 1)) begin
            det_d.win   = '0;
            det_d.edges = '0;
        end else begin
            det_d.win = det_q.win + WIN_W'(1);
            if (rise && det_q.edges != EDGE_W'(EDGES_NEEDED))
                det_d.edges = det_q.edges + EDGE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) det_q <= '0;
        else        det_q <= det_d;
    end

    assign alive_o = enable_i && (det_q.edges == EDGE_W'(EDGES_NEEDED));

    // The edge count never exceeds the number needed (R8)
    assert_edge_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        det_q.edges <= EDGE_W'(EDGES_NEEDED));

    // A disabled detector holds no edges (R8)
    assert_clear_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (det_q.edges == '0));

endmodule

// File: rtl/aclink_pm_seq.sv
module aclink_pm_seq
    import aclink_pm_pkg::*;
#(
    parameter longint SYS_CLK_HZ   = 125_000_000,
    parameter longint BCLK_HZ      = 12_288_000,
    parameter int     FRAME_BITS   = 256,
    parameter int     LOCK_FRAMES  = 4,
    parameter longint PULSE_NS     = 1000,
    parameter int     WINDOW_CYC   = 64,
    parameter int     EDGES_NEEDED = 3,
    parameter int     SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_clk_i,
    input  logic       sync_i,
    input  logic       sdo_i,
    input  logic       pd_arm_i,
    input  logic       pd_cut_i,
    input  logic       wake_req_i,
    output logic       sync_o,
    output logic       sdo_o,
    output logic       data_slot_en_o,
    output logic       link_up_o,
    output logic [2:0] state_o
);

    localparam longint FRAME_CYC = ceil_div(longint'(FRAME_BITS) * SYS_CLK_HZ, BCLK_HZ);
    localparam longint LOCK_CYC  = FRAME_CYC * longint'(LOCK_FRAMES);
    localparam longint PULSE_CYC = ceil_div(SYS_CLK_HZ * PULSE_NS, 64'd1_000_000_000);
    localparam longint MAX_CYC   = (LOCK_CYC > PULSE_CYC) ? LOCK_CYC : PULSE_CYC;
    localparam int     CNT_W     = $clog2(MAX_CYC + 1);

    seq_s             seq_d, seq_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             clk_alive;
    logic             link_on;

    aclink_pm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    aclink_bclk_detect #(
        .SYNC_STAGES  (SYNC_STAGES),
        .WINDOW_CYC   (WINDOW_CYC),
        .EDGES_NEEDED (EDGES_NEEDED)
    ) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_i   (bit_clk_i),
        .enable_i (seq_q.st == ST_WAITCLK),
        .alive_o  (clk_alive)
    );

    always_comb begin
        seq_d    = seq_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (seq_q.st)
            ST_RUN: begin
                if (pd_arm_i) seq_d.st = ST_PDFRM;
            end
            ST_PDFRM: begin
                if (pd_cut_i) begin
                    seq_d.st   = ST_LOCK;
                    seq_d.pend = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = CNT_W'(LOCK_CYC);
                end
            end
            ST_LOCK: begin
                if (wake_req_i) seq_d.pend = 1'b1;
                if (tmr_done) begin
                    if (seq_q.pend || wake_req_i) begin
                        seq_d.st = ST_WAKE;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(PULSE_CYC);
                    end else begin
                        seq_d.st = ST_DOWN;
                    end
                end
            end
            ST_DOWN: begin
                if (wake_req_i) begin
                    seq_d.st = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(PULSE_CYC);
                end
            end
            ST_WAKE: begin
                seq_d.pend = 1'b0;
                if (tmr_done) seq_d.st = ST_WAITCLK;
            end
            ST_WAITCLK: begin
                if (clk_alive) seq_d.st = ST_RUN;
            end
            default: seq_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_RUN, pend: 1'b0};
        else        seq_q <= seq_d;
    end

    assign link_on        = (seq_q.st == ST_RUN) || (seq_q.st == ST_PDFRM);
    assign sync_o         = (seq_q.st == ST_WAKE) || (link_on && sync_i);
    assign sdo_o          = link_on && sdo_i;
    assign data_slot_en_o = (seq_q.st == ST_RUN);
    assign link_up_o      = link_on;
    assign state_o        = seq_q.st;

    // Link outputs stay low while the codec is powered down (R4)
    assert_quiet_lines_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st inside {ST_LOCK, ST_DOWN, ST_WAITCLK}) |-> (!sync_o && !sdo_o));

    // The lockout is entered only from the power-down frame (R4)
    assert_lock_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_LOCK && $past(seq_q.st) != ST_LOCK) |-> ($past(seq_q.st) == ST_PDFRM));

    // The wake pulse starts only from the lockout or the down state (R6)
    assert_wake_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_WAKE && $past(seq_q.st) != ST_WAKE) |-> ($past(seq_q.st) inside {ST_LOCK, ST_DOWN}));

    // The lockout ends only after the timer has run out (R5)
    assert_lock_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_LOCK && !tmr_done) |=> (seq_q.st == ST_LOCK));

    // A wake request during the lockout is never lost (R7)
    assert_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_LOCK && wake_req_i) |=> (seq_q.st == ST_WAKE || seq_q.pend));

    // Running resumes from the wait state only once the clock is seen (R8)
    assert_run_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_RUN && $past(seq_q.st) == ST_WAITCLK) |-> $past(clk_alive));

endmodule

// File: tb/tb_aclink_pm_seq.sv
module tb_aclink_pm_seq;

    localparam int LOCK_N  = 10420;  // 4 * ceil(256 * 125e6 / 12.288e6)
    localparam int PULSE_N = 125;    // ceil(125e6 * 1e-6)

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b0;
    logic bclk_en = 1'b0;
    logic sync_i = 1'b0, sdo_i = 1'b0;
    logic pd_arm = 1'b0, pd_cut = 1'b0, wake = 1'b0;
    logic sync_o, sdo_o, slot_en, link_up;
    logic [2:0] st;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    initial begin
        forever begin
            if (bclk_en) #40 bclk = ~bclk;
            else         #4;
        end
    end

    aclink_pm_seq dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_clk_i      (bclk),
        .sync_i         (sync_i),
        .sdo_i          (sdo_i),
        .pd_arm_i       (pd_arm),
        .pd_cut_i       (pd_cut),
        .wake_req_i     (wake),
        .sync_o         (sync_o),
        .sdo_o          (sdo_o),
        .data_slot_en_o (slot_en),
        .link_up_o      (link_up),
        .state_o        (st)
    );

    // {sync_i, sdo_i, expected sync_o, expected sdo_o}
    localparam logic [3:0] VEC [0:3] = '{4'b0000, 4'b0101, 4'b1010, 4'b1111};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic burst(input int n);
        for (int i = 0; i < n; i++) begin
            #40 bclk = 1'b1;
            #40 bclk = 1'b0;
        end
    endtask

    task automatic wait_run(input string req);
        int k;
        k = 0;
        while (st != 3'd0 && k < 400) begin
            step(1);
            k++;
        end
        chk(req, int'(st), 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 state", int'(st), 0);
        chk("R1 link_up", int'(link_up), 1);
        chk("R1 slot_en", int'(slot_en), 1);

        // R1/R2 pass-through table
        foreach (VEC[i]) begin
            sync_i = VEC[i][3];
            sdo_i  = VEC[i][2];
            #1;
            chk("R2 sync pass", int'(sync_o), int'(VEC[i][1]));
            chk("R2 sdo pass", int'(sdo_o), int'(VEC[i][0]));
        end

        // R2 wake and cut ignored while running
        sync_i = 1'b0; sdo_i = 1'b1;
        wake = 1'b1; pd_cut = 1'b1;
        step(1);
        wake = 1'b0; pd_cut = 1'b0;
        chk("R2 ignored state", int'(st), 0);
        chk("R2 ignored sync", int'(sync_o), 0);
        chk("R2 ignored sdo", int'(sdo_o), 1);

        // R3 power-down frame
        pd_arm = 1'b1;
        step(1);
        pd_arm = 1'b0;
        sync_i = 1'b1;
        #1;
        chk("R3 state", int'(st), 1);
        chk("R9 slot_en pdframe", int'(slot_en), 0);
        chk("R3 link_up", int'(link_up), 1);
        chk("R3 sync pass", int'(sync_o), 1);

        // R4 cut point
        pd_cut = 1'b1;
        step(1);
        pd_cut = 1'b0;
        bclk_en = 1'b0;
        chk("R4 state", int'(st), 2);
        chk("R4 sync low", int'(sync_o), 0);
        chk("R4 sdo low", int'(sdo_o), 0);
        chk("R4 link_up", int'(link_up), 0);

        // R5 lockout length
        step(LOCK_N - 1);
        chk("R5 last lockout cycle", int'(st), 2);
        step(1);
        chk("R5 down", int'(st), 3);
        chk("R4 down sync low", int'(sync_o), 0);
        chk("R9 slot_en down", int'(slot_en), 0);

        // R6 wake pulse
        wake = 1'b1;
        step(1);
        wake = 1'b0;
        chk("R6 state", int'(st), 4);
        chk("R6 sync high", int'(sync_o), 1);
        chk("R6 sdo low", int'(sdo_o), 0);
        step(PULSE_N - 1);
        chk("R6 last pulse cycle", int'(sync_o), 1);
        step(1);
        chk("R6 wait state", int'(st), 5);
        chk("R6 sync dropped", int'(sync_o), 0);

        // R8 no clock, then only two edges
        step(300);
        chk("R8 no clock", int'(st), 5);
        burst(2);
        step(200);
        chk("R8 two edges", int'(st), 5);
        chk("R4 wait sdo low", int'(sdo_o), 0);
        bclk_en = 1'b1;
        wait_run("R8 clock back");
        chk("R8 link_up", int'(link_up), 1);
        chk("R9 slot_en run", int'(slot_en), 1);
        chk("R1 sync pass again", int'(sync_o), 1);

        // R7 wake held during lockout
        pd_arm = 1'b1;
        step(1);
        pd_arm = 1'b0;
        pd_cut = 1'b1;
        step(1);
        pd_cut = 1'b0;
        bclk_en = 1'b0;
        step(1000);
        wake = 1'b1;
        step(1);
        wake = 1'b0;
        chk("R7 still lockout", int'(st), 2);
        step(LOCK_N - 1 - 1001);
        chk("R7 lockout not shortened", int'(st), 2);
        step(1);
        chk("R7 direct wake", int'(st), 4);
        chk("R7 sync high", int'(sync_o), 1);
        step(PULSE_N);
        chk("R7 wait state", int'(st), 5);
        bclk_en = 1'b1;
        wait_run("R8 second return");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule